// File: doc/BRIEF.md
# Tape Formatter Register File and Command Gate

This block is the software-visible face of a 16-bit magnetic tape formatter. It decodes a seven-register offset space. That space holds a command register, formatter status, error flags, a scratch maintenance word, an attention summary, a frame count and a tape control word. When a command is posted with its go bit set, the block decides in the same clock whether the command may run.

Three things can happen to a posted command:
- It is finished on the spot: no-op, formatter clear or read-in preset.
- It is handed to an external motion/transfer sequencer through a one-cycle start strobe.
- It is refused. The matching error bit is set and attention is raised.

Drive mechanics and data movement are outside the block. It sees the selected drive only through five level inputs: busy, attached, write-protected, at beginning of tape and at end of tape. The sequencer reports completion with a done strobe. That strobe may carry tape-mark and ID-burst flags.

Top module: `tape_fmt_regs`

## Requirements
- R1: After reset the command, frame count, error, tape control and maintenance registers and the attention flag read zero. With an idle, unattached drive the status register reads 0x00C0 (present bit 7, ready bit 6).
- R2: Register offsets are 0 command, 1 status, 2 error, 3 maintenance, 4 attention summary, 5 frame count and 6 tape control. Any read or write at offsets 7 to 15 raises `reg_nxr` in that cycle and changes no register.
- R3: While go is set, writes to offsets 0, 1, 2, 5 and 6 are discarded. Each such write sets error bit 1 (modify refused) and raises attention.
- R4: An accepted frame count write sets frame-count-status (tape control bit 14). A tape control write stores the bits under mask 0x17FF and sets address-change (bit 13). Bit 14 cannot be written. Tape control fields are drive [2:0], format [7:4] and density [10:8]. The maintenance register stores all 16 bits.
- R5: Reading offset 4 returns the attention flag in bit 0. Writing offset 4 with bit 0 set clears attention; with bit 0 clear it has no effect.
- R6: The command register holds go in bit 0 and the function code in bits 5:1. A go with any function other than 4 (formatter clear) is refused when any error bit is set or the drive is busy. A refusal sets error bit 0 (illegal function), leaves go clear and raises attention.
- R7: Formatter clear (code 4) runs whenever it is posted. It zeroes the error register, clears frame-count-status and the ID-burst status bit, and pulses `drv_cancel`. Every accepted go clears attention and address-change.
- R8: Write (24) is refused with error bit 3 (nonexecutable) in either of two cases: frame-count-status is clear, or density is 3 and the frame count exceeds 0xFFF5. Write, erase (10) and write tape mark (11) are also refused with bit 3 when the drive is write-protected.
- R9: Read-in preset (code 8) loads tape control with 0x03C0 (density 3, format 12). It clears the tape-mark status bit and pulses `rip_rewind`.
- R10: Unload (1), rewind (3), space forward/reverse (12/13) and codes 10, 11, 20, 24 and 28 set error bit 4 (unsafe) when the drive is unattached. Codes 23 and 31 do the same once the drive is not at beginning of tape. The data transfer codes (10, 11, 20, 23, 24, 28, 31) set error bit 2 when the format is neither 12 nor 13. Space forward at end of tape, space reverse at beginning of tape and either space with frame-count-status clear set bit 3. Read or write check reverse (31/23) at beginning of tape also sets bit 3.
- R11: An accepted motion or transfer command keeps go set and pulses `cmd_start` for one cycle, with `cmd_func` equal to the code. `cmd_done` clears go; it raises attention only for codes below 20, and it records the tape-mark and ID-burst flags.
- R12: Status bits are:
  - 0: at beginning of tape (attached and idle)
  - 1: tape mark
  - 2: ID burst
  - 3: density 4 (attached)
  - 4: at end of tape (attached and idle)
  - 5: write-protected (attached)
  - 6: ready (not busy)
  - 7: present
  - 8: attached
  - 9: busy (attached)
  - 10: OR of all error bits
  - 11: attention

  Any event that sets an error bit also raises attention.
- R13: Function codes outside the listed set set error bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| reg_nxr | output | 1 | Nonexistent register response |
| drv_busy | input | 1 | Selected drive in motion |
| drv_attached | input | 1 | Selected drive has medium loaded |
| drv_wprot | input | 1 | Selected drive write-protected |
| drv_bot | input | 1 | Selected drive at beginning of tape |
| drv_eot | input | 1 | Selected drive at end of tape |
| cmd_done | input | 1 | Sequencer completion strobe |
| done_tmk | input | 1 | Tape mark seen by completed command |
| done_id | input | 1 | ID burst seen by completed command |
| cmd_start | output | 1 | One-cycle dispatch strobe |
| cmd_func | output | 5 | Function code of the current command |
| cmd_drive | output | 3 | Selected drive number |
| drv_cancel | output | 1 | Cancel drive activity pulse |
| rip_rewind | output | 1 | Rewind drive 0 pulse |
| attn | output | 1 | Attention flag |

## Verification
Command acceptance is driven through every branch of the precondition ladder, so that each error bit is provoked by exactly one cause:
- an unattached drive
- a bad format
- a missing frame-count-status
- a frame count one step past the dense-write limit, against 0xFFF5 exactly
- write protection
- beginning and end of tape
- a busy drive
- a pending error
- an unlisted code

Formatter clear is issued after each refusal. This shows that it alone bypasses the pending-error gate, and it separates sticky bits (tape mark) from those it clears (ID burst). Register writes are tried with go clear and with go set, to distinguish stored writes from refused ones. Completion is exercised for a transfer code and a motion code, to tell the two attention rules apart.

// File: rtl/tape_fmt_regs.sv
module tape_fmt_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        reg_nxr,
  input  logic        drv_busy,
  input  logic        drv_attached,
  input  logic        drv_wprot,
  input  logic        drv_bot,
  input  logic        drv_eot,
  input  logic        cmd_done,
  input  logic        done_tmk,
  input  logic        done_id,
  output logic        cmd_start,
  output logic [4:0]  cmd_func,
  output logic [2:0]  cmd_drive,
  output logic        drv_cancel,
  output logic        rip_rewind,
  output logic        attn
);
  localparam logic [3:0] A_CMD = 4'd0, A_STS = 4'd1, A_ERR = 4'd2, A_MNT = 4'd3,
                         A_ATN = 4'd4, A_FCT = 4'd5, A_TCR = 4'd6;
  localparam int EB_ILF = 0, EB_RMR = 1, EB_FER = 2, EB_NXF = 3, EB_UNS = 4;
  localparam int TC_SAC = 13, TC_FCS = 14;
  localparam logic [15:0] TC_WMASK  = 16'h17FF;
  localparam logic [15:0] TC_PRESET = 16'h03C0;
  localparam logic [15:0] FC_LIMIT  = 16'hFFF5;
  localparam logic [4:0] F_NOP = 5'd0, F_UNL = 5'd1, F_REW = 5'd3, F_CLR = 5'd4,
                         F_RIP = 5'd8, F_ERA = 5'd10, F_WTM = 5'd11, F_SPF = 5'd12,
                         F_SPR = 5'd13, F_WCF = 5'd20, F_WCR = 5'd23, F_WRT = 5'd24,
                         F_RDF = 5'd28, F_RDR = 5'd31;
  localparam logic [4:0] F_XFER = 5'd20;

  typedef enum logic [2:0] {K_START, K_NOP, K_CLR, K_RIP} kind_t;

  logic        go_q, attn_q, tmk_q, id_q, start_q, cancel_q, rip_q;
  logic [4:0]  func_q, err_q;
  logic [15:0] fc_q, tc_q, mr_q;

  logic        valid, rmr, is_cmd_go, reject;
  logic [4:0]  nf, rej, dchk;
  logic [2:0]  dens;
  logic [3:0]  fmt;
  logic        fcs, fmt_ok, at_bot, at_eot;
  kind_t       kind;
  logic [15:0] status;

  assign valid     = reg_addr <= A_TCR;
  assign reg_nxr   = (reg_wr | reg_rd) & ~valid;
  assign nf        = reg_wdata[5:1];
  assign dens      = tc_q[10:8];
  assign fmt       = tc_q[7:4];
  assign fcs       = tc_q[TC_FCS];
  assign fmt_ok    = (fmt == 4'd12) || (fmt == 4'd13);
  assign at_bot    = drv_attached & ~drv_busy & drv_bot;
  assign at_eot    = drv_attached & ~drv_busy & drv_eot;
  assign dchk      = !drv_attached ? (5'b1 << EB_UNS) : (!fmt_ok ? (5'b1 << EB_FER) : 5'b0);
  assign is_cmd_go = reg_wr && reg_addr == A_CMD && !go_q && reg_wdata[0];
  assign rmr       = reg_wr && go_q &&
                     (reg_addr == A_CMD || reg_addr == A_STS || reg_addr == A_ERR ||
                      reg_addr == A_FCT || reg_addr == A_TCR);
  assign reject    = |rej;

  always_comb begin
    rej  = '0;
    kind = K_START;
    if (nf != F_CLR && ((|err_q) || drv_busy)) rej = 5'b1 << EB_ILF;
    else begin
      case (nf)
        F_NOP: kind = K_NOP;
        F_CLR: kind = K_CLR;
        F_RIP: kind = K_RIP;
        F_UNL, F_REW: if (!drv_attached) rej = 5'b1 << EB_UNS;
        F_SPF: if (!drv_attached) rej = 5'b1 << EB_UNS;
               else if (at_eot || !fcs) rej = 5'b1 << EB_NXF;
        F_SPR: if (!drv_attached) rej = 5'b1 << EB_UNS;
               else if (drv_bot || !fcs) rej = 5'b1 << EB_NXF;
        F_WCR, F_RDR: if (at_bot) rej = 5'b1 << EB_NXF;
                      else rej = dchk;
        F_WRT: if (!fcs || (dens == 3'd3 && fc_q > FC_LIMIT)) rej = 5'b1 << EB_NXF;
               else if (drv_wprot) rej = 5'b1 << EB_NXF;
               else rej = dchk;
        F_ERA, F_WTM: if (drv_wprot) rej = 5'b1 << EB_NXF;
                      else rej = dchk;
        F_WCF, F_RDF: rej = dchk;
        default: rej = 5'b1 << EB_ILF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q <= 1'b0; func_q <= '0; fc_q <= '0; tc_q <= '0; mr_q <= '0; err_q <= '0;
      attn_q <= 1'b0; tmk_q <= 1'b0; id_q <= 1'b0;
      start_q <= 1'b0; cancel_q <= 1'b0; rip_q <= 1'b0;
    end else begin
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
      rip_q    <= 1'b0;
      if (cmd_done && go_q) begin
        go_q <= 1'b0;
        if (func_q < F_XFER) attn_q <= 1'b1;
        if (done_tmk) tmk_q <= 1'b1;
        if (done_id) id_q <= 1'b1;
      end
      if (rmr) begin
        err_q[EB_RMR] <= 1'b1;
        attn_q <= 1'b1;
      end else if (reg_wr && valid) begin
        case (reg_addr)
          A_CMD: begin
            func_q <= nf;
            if (is_cmd_go) begin
              if (reject) begin
                err_q  <= err_q | rej;
                attn_q <= 1'b1;
              end else begin
                attn_q <= 1'b0;
                tc_q[TC_SAC] <= 1'b0;
                case (kind)
                  K_START: begin
                    go_q <= 1'b1; start_q <= 1'b1; tmk_q <= 1'b0; id_q <= 1'b0;
                  end
                  K_CLR: begin
                    err_q <= '0; tc_q[TC_FCS] <= 1'b0; id_q <= 1'b0; cancel_q <= 1'b1;
                  end
                  K_RIP: begin
                    tc_q <= TC_PRESET; tmk_q <= 1'b0; rip_q <= 1'b1;
                  end
                  default: ;
                endcase
              end
            end
          end
          A_MNT: mr_q <= reg_wdata;
          A_ATN: if (reg_wdata[0]) attn_q <= 1'b0;
          A_FCT: begin
            fc_q <= reg_wdata;
            tc_q[TC_FCS] <= 1'b1;
          end
          A_TCR: tc_q <= (tc_q & ~TC_WMASK) | (reg_wdata & TC_WMASK) | (16'b1 << TC_SAC);
          default: ;
        endcase
      end
    end
  end

  assign status = {4'b0, attn_q, |err_q, drv_attached & drv_busy, drv_attached, 1'b1,
                   ~drv_busy, drv_attached & drv_wprot, at_eot,
                   drv_attached & (dens == 3'd4), id_q, tmk_q, at_bot};

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {10'b0, func_q, go_q};
      A_STS:   reg_rdata = status;
      A_ERR:   reg_rdata = {11'b0, err_q};
      A_MNT:   reg_rdata = mr_q;
      A_ATN:   reg_rdata = {15'b0, attn_q};
      A_FCT:   reg_rdata = fc_q;
      A_TCR:   reg_rdata = tc_q;
      default: reg_rdata = '0;
    endcase
  end

  assign cmd_start  = start_q;
  assign cmd_func   = func_q;
  assign cmd_drive  = tc_q[2:0];
  assign drv_cancel = cancel_q;
  assign rip_rewind = rip_q;
  assign attn       = attn_q;

  AST_REFUSED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rmr |=> err_q[EB_RMR] && attn_q); // R3
  AST_FC_WRITE_SETS_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !go_q && reg_addr == A_FCT) |=> tc_q[TC_FCS]); // R4
  AST_NXR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_nxr |=> $stable(fc_q) && $stable(tc_q) && $stable(mr_q)); // R2
  AST_ERROR_RAISES_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|err_q) |-> attn_q); // R12
  AST_START_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> go_q); // R11
  AST_REJECT_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd_go && reject) |=> !go_q && attn_q); // R6
endmodule

// File: tb/tape_fmt_regs_tb_top.sv
module tape_fmt_regs_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        reg_nxr;
  logic        drv_busy = 0, drv_attached = 0, drv_wprot = 0, drv_bot = 0, drv_eot = 0;
  logic        cmd_done = 0, done_tmk = 0, done_id = 0;
  logic        cmd_start, drv_cancel, rip_rewind, attn;
  logic [4:0]  cmd_func;
  logic [2:0]  cmd_drive;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tape_fmt_regs dut_i (.*);

  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'd5, 16'h1234, 16'h0000},
    {1'b0, 4'd5, 16'h0000, 16'h1234},
    {1'b0, 4'd6, 16'h0000, 16'h4000},
    {1'b1, 4'd6, 16'hFFFF, 16'h0000},
    {1'b0, 4'd6, 16'h0000, 16'h77FF},
    {1'b1, 4'd3, 16'hA5A5, 16'h0000},
    {1'b0, 4'd3, 16'h0000, 16'hA5A5},
    {1'b1, 4'd6, 16'h0000, 16'h0000},
    {1'b0, 4'd6, 16'h0000, 16'h6000},
    {1'b1, 4'd1, 16'hFFFF, 16'h0000},
    {1'b0, 4'd2, 16'h0000, 16'h0000},
    {1'b0, 4'd4, 16'h0000, 16'h0000}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    reg_rd = 0;
  endtask

  task automatic done_pulse(logic t, logic i);
    @(negedge clk);
    cmd_done = 1; done_tmk = t; done_id = i;
    @(negedge clk);
    cmd_done = 0; done_tmk = 0; done_id = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 16'h0000, "R1 cmd"); rd(1, 16'h00C0, "R1 status"); rd(2, 16'h0000, "R1 err");
    rd(5, 16'h0000, "R1 fc");  rd(6, 16'h0000, "R1 tc");     rd(3, 16'h0000, "R1 maint");
    check("R1 attn", {15'b0, attn}, 16'h0);
    // R12 status composition
    drv_attached = 1; drv_bot = 1;
    rd(1, 16'h01C1, "R12 attached at bot");
    drv_busy = 1;
    rd(1, 16'h0380, "R12 busy");
    drv_wprot = 1;
    rd(1, 16'h03A0, "R12 busy wprot");
    drv_busy = 0; drv_wprot = 0; drv_bot = 0; drv_attached = 0;
    // R2 nonexistent offsets
    @(negedge clk); reg_rd = 1; reg_addr = 4'd9;
    #1 check("R2 nxr on read", {15'b0, reg_nxr}, 16'h1);
    reg_rd = 0;
    @(negedge clk); reg_wr = 1; reg_addr = 4'd12; reg_wdata = 16'hFFFF;
    #1 check("R2 nxr on write", {15'b0, reg_nxr}, 16'h1);
    @(negedge clk); reg_wr = 0;
    rd(6, 16'h0000, "R2 tc untouched"); rd(5, 16'h0000, "R2 fc untouched");
    // table: R4 register side effects, R5 attention summary
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][36]) wr(VEC[k][35:32], VEC[k][31:16]);
      else rd(VEC[k][35:32], VEC[k][15:0], $sformatf("R4/R5 table vector %0d", k));
    end
    drv_attached = 1;
    // R10 format error on transfer
    wr(0, 16'h0039);
    rd(2, 16'h0004, "R10 format error"); rd(0, 16'h0038, "R10 go clear");
    check("R12 attn on error", {15'b0, attn}, 16'h1);
    // R6 pending error blocks go
    wr(0, 16'h0039);
    rd(2, 16'h0005, "R6 illegal with pending error");
    // R7 formatter clear
    wr(0, 16'h0009);
    check("R7 cancel pulse", {15'b0, drv_cancel}, 16'h1);
    rd(2, 16'h0000, "R7 err zeroed"); rd(6, 16'h0000, "R7 fcs and sac cleared");
    check("R7 attn cleared", {15'b0, attn}, 16'h0);
    wr(6, 16'h00C0); rd(6, 16'h20C0, "R4 sac on tc write");
    wr(5, 16'hFFF0); rd(6, 16'h60C0, "R4 fcs on fc write");
    // R11 dispatch
    wr(0, 16'h0039);
    check("R11 start", {15'b0, cmd_start}, 16'h1);
    check("R11 func", {11'b0, cmd_func}, 16'd28);
    rd(0, 16'h0039, "R11 go held"); rd(6, 16'h40C0, "R7 sac cleared on accept");
    // R3 refused writes while go
    wr(5, 16'h0001); rd(5, 16'hFFF0, "R3 fc kept"); rd(2, 16'h0002, "R3 rmr flag");
    check("R3 attn", {15'b0, attn}, 16'h1);
    wr(6, 16'h0000); rd(6, 16'h40C0, "R3 tc kept");
    wr(0, 16'h0000); rd(0, 16'h0039, "R3 cmd kept");
    // R11 transfer completion does not raise attention
    wr(4, 16'h0001);
    done_pulse(1, 1);
    rd(0, 16'h0038, "R11 done clears go");
    check("R11 no attn for transfer", {15'b0, attn}, 16'h0);
    rd(1, 16'h05C6, "R12 tmk id err bits");
    wr(0, 16'h0009);
    rd(1, 16'h01C2, "R7 id cleared tmk kept"); rd(6, 16'h00C0, "R7 fcs cleared");
    // R9 read-in preset
    wr(0, 16'h0011);
    check("R9 rewind pulse", {15'b0, rip_rewind}, 16'h1);
    rd(6, 16'h03C0, "R9 tc preset"); rd(1, 16'h01C0, "R9 tmk cleared");
    rd(0, 16'h0010, "R9 go clear");
    // R8 write refusals
    wr(0, 16'h0031); rd(2, 16'h0008, "R8 write without fcs");
    wr(0, 16'h0009);
    wr(5, 16'hFFF6); wr(0, 16'h0031); rd(2, 16'h0008, "R8 dense frame count over limit");
    wr(0, 16'h0009);
    wr(5, 16'hFFF0); drv_wprot = 1;
    wr(0, 16'h0031); rd(2, 16'h0008, "R8 write protected");
    wr(0, 16'h0009);
    wr(0, 16'h0015); rd(2, 16'h0008, "R8 erase protected");
    wr(0, 16'h0009);
    wr(0, 16'h0017); rd(2, 16'h0008, "R8 tape mark protected");
    wr(0, 16'h0009); drv_wprot = 0;
    wr(5, 16'hFFF5); wr(0, 16'h0031);
    check("R8 write at limit accepted", {15'b0, cmd_start}, 16'h1);
    check("R8 func write", {11'b0, cmd_func}, 16'd24);
    done_pulse(0, 0);
    check("R11 attn stays low", {15'b0, attn}, 16'h0);
    // R11 motion completion raises attention
    wr(0, 16'h0019);
    check("R11 space start", {15'b0, cmd_start}, 16'h1);
    done_pulse(0, 0);
    check("R11 attn after space", {15'b0, attn}, 16'h1);
    rd(0, 16'h0018, "R11 space go cleared");
    wr(4, 16'h0001);
    // R10 unattached and positional refusals
    drv_attached = 0;
    wr(0, 16'h0007); rd(2, 16'h0010, "R10 rewind unattached");
    wr(0, 16'h0009); drv_attached = 1; drv_bot = 1;
    wr(5, 16'hFFFF); wr(0, 16'h001B); rd(2, 16'h0008, "R10 space reverse at bot");
    wr(0, 16'h0009);
    wr(0, 16'h003F); rd(2, 16'h0008, "R10 read reverse at bot");
    wr(0, 16'h0009); drv_bot = 0; drv_eot = 1;
    wr(5, 16'hFFFF); wr(0, 16'h0019); rd(2, 16'h0008, "R10 space forward at eot");
    wr(0, 16'h0009); drv_eot = 0;
    // R6 busy drive
    drv_busy = 1;
    wr(0, 16'h0001); rd(2, 16'h0001, "R6 busy refuses nop");
    wr(0, 16'h0009); rd(2, 16'h0000, "R7 clear runs while busy");
    drv_busy = 0;
    // R13 unlisted code
    wr(0, 16'h0005); rd(2, 16'h0001, "R13 code 2 illegal");
    // R5 attention summary
    rd(4, 16'h0001, "R5 attn read");
    wr(4, 16'h0000); rd(4, 16'h0001, "R5 write without bit0 ignored");
    wr(4, 16'h0001); rd(4, 16'h0000, "R5 attn cleared");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule